// File: doc/BRIEF.md
# Oscillator phase sequencing controller

This block is the digital sequencer for a relaxation oscillator in a switching power controller. It watches three comparator flags on the timing-capacitor voltage: below the valley threshold, below the intermediate threshold, and at or above the peak threshold. It also takes a sync level, a sync-mode select, a dead-time flag and the PWM latch output. From these it enables one of three current sources on the capacitor: charge, discharge or regulation. It also produces two timing signals, `sf` and `vs`, for the PWM logic.

Two state bits, both clocked by `clk`, track the cycle. The cycle bit is high from the end of discharge until the end of charge. The charge bit is high only while the capacitor is charging. When the cycle bit is high and the charge bit is low, the capacitor sits in a regulation hold. It stays there until the dead-time flag and the sync condition allow a new charge. In free-running mode (`sync_mode` low) the sync condition is always true and charging ends at the peak. In synchronized mode, charging ends once the voltage is above the intermediate threshold while the sync level is low. This holds for wide and narrow sync pulses alike.

Top module: `osc_phase_seq`

## Requirements
- R1: While `rst_n` is low, both state bits clear. The outputs are then `chg_en`=0, `reg_en`=0, `sf`=0, `vs`=0, and `dis_en` = NOT `below_valley`.
- R2: `dis_en` is 1 exactly when the cycle bit is 0 and `below_valley` is 0. It drops in the same cycle `below_valley` rises, without waiting for a clock edge.
- R3: From discharge, the cycle bit sets on the first rising clock edge that sees `below_valley`=1. After that edge, `reg_en`=1 for as long as the cycle bit is 1 and the charge bit is 0.
- R4: The charge bit sets on a clock edge only if the cycle bit is 1, the sync condition is true and `dead_time`=1. `chg_en` equals the charge bit, and the charge bit never stands without the cycle bit.
- R5: In free mode (`sync_mode`=0), an edge that sees `at_peak`=1 during charge clears both bits, so discharge follows on the next cycle.
- R6: In synchronized mode (`sync_mode`=1), the sync condition equals `sync_in`. Charging ends at the edge that sees `below_mid`=0 and `sync_in`=0. While `sync_in`=1, charging continues past the intermediate level, and `at_peak` is ignored.
- R7: `sf` = charge bit AND `below_mid`. It is a combinational output.
- R8: `vs` follows `sf` while `pwm_latch`=0. It goes low in the same cycle `pwm_latch` goes to 1 during a cycle. It stays low, even after `pwm_latch` returns to 0, until the cycle bit has been low for one clock edge.
- R9: In free mode, `sync_in` has no effect. `below_mid`=0 does not end a charge.
- R10: While `dead_time`=0, the block stays in the regulation hold, whatever the sync inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_mode | input | 1 | 1 = synchronized mode, 0 = free-running |
| sync_in | input | 1 | Digitized sync level (1 = above the sync threshold) |
| dead_time | input | 1 | Dead-time elapsed flag from the demagnetization logic |
| below_valley | input | 1 | Capacitor voltage below the valley threshold |
| below_mid | input | 1 | Capacitor voltage below the intermediate threshold |
| at_peak | input | 1 | Capacitor voltage at or above the peak threshold |
| pwm_latch | input | 1 | PWM latch output |
| chg_en | output | 1 | Charge current source enable |
| dis_en | output | 1 | Discharge current source enable |
| reg_en | output | 1 | Regulation current source enable |
| sf | output | 1 | Early-charge window (charging and below intermediate) |
| vs | output | 1 | Blanked early-charge window for the PWM logic |

## Verification
The assertions check the state invariants on every cycle:
- the charge bit implies the cycle bit;
- a charge starts only under the gating condition;
- each mode's end-of-charge condition clears both bits on the next edge;
- `vs` is held low after the PWM latch fires.

Only the bench's scenarios can show the full ordering. This covers discharge, regulation hold and charge in both modes, a wide sync pulse that keeps charging past the intermediate level, and the release of the `vs` blanking in the next cycle. An exhaustive sweep of every flag combination in every phase confirms the combinational enables.

// File: rtl/osc_phase_seq.sv
module osc_phase_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_mode,
  input  logic sync_in,
  input  logic dead_time,
  input  logic below_valley,
  input  logic below_mid,
  input  logic at_peak,
  input  logic pwm_latch,
  output logic chg_en,
  output logic dis_en,
  output logic reg_en,
  output logic sf,
  output logic vs
);

  logic cyc_q;
  logic chg_q;
  logic blank_q;
  logic sync_ok;
  logic chg_done;
  logic chg_start;

  assign sync_ok   = !sync_mode || sync_in;
  assign chg_done  = chg_q && (sync_mode ? (!below_mid && !sync_in) : at_peak);
  assign chg_start = cyc_q && sync_ok && dead_time;

  // cycle bit: reset has priority over set
  always_ff @(posedge clk) begin
    if (!rst_n)                       cyc_q <= 1'b0;
    else if (chg_done)                cyc_q <= 1'b0;
    else if (!cyc_q && below_valley)  cyc_q <= 1'b1;
  end

  // charge bit: shares the cycle bit's reset term
  always_ff @(posedge clk) begin
    if (!rst_n)          chg_q <= 1'b0;
    else if (chg_done)   chg_q <= 1'b0;
    else if (chg_start)  chg_q <= 1'b1;
  end

  // remembers a PWM set within the current cycle
  always_ff @(posedge clk) begin
    if (!rst_n)          blank_q <= 1'b0;
    else if (!cyc_q)     blank_q <= 1'b0;
    else if (pwm_latch)  blank_q <= 1'b1;
  end

  assign chg_en = chg_q;
  assign reg_en = cyc_q && !chg_q;
  assign dis_en = !cyc_q && !below_valley;
  assign sf     = chg_q && below_mid;
  assign vs     = sf && !pwm_latch && !blank_q;

  // R4
  chg_needs_cyc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg_en |-> !dis_en && !reg_en);

  // R4
  chg_start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chg_en) |-> $past(reg_en && dead_time && (!sync_mode || sync_in)));

  // R5
  free_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_en && !sync_mode && at_peak) |=> (!chg_en && !reg_en));

  // R6
  sync_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_en && sync_mode && !below_mid && !sync_in) |=> (!chg_en && !reg_en));

  // R8
  vs_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((chg_en || reg_en) && pwm_latch) |=> !vs);

  // R10
  dead_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && !dead_time) |=> !chg_en);

endmodule

// File: tb/osc_phase_seq_tb.sv
`timescale 1ns/1ps
module osc_phase_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sm = 1'b0, si = 1'b0, dt = 1'b0, bv = 1'b0, bm = 1'b1, pk = 1'b0, pwm = 1'b0;
  logic chg_en, dis_en, reg_en, sf, vs;
  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  osc_phase_seq u_dut (
    .clk(clk), .rst_n(rst_n), .sync_mode(sm), .sync_in(si), .dead_time(dt),
    .below_valley(bv), .below_mid(bm), .at_peak(pk), .pwm_latch(pwm),
    .chg_en(chg_en), .dis_en(dis_en), .reg_en(reg_en), .sf(sf), .vs(vs)
  );

  task automatic chk(input string tag, input logic [4:0] exp);
    logic [4:0] act;
    act = {chg_en, dis_en, reg_en, sf, vs};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s {chg,dis,reg,sf,vs} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic hold(input logic mode);
    sm = mode; si = 1'b1; dt = 1'b0; bv = 1'b0; bm = 1'b1; pk = 1'b0; pwm = 1'b0;
  endtask

  // phase 0 discharge, 1 regulation, 2 charge
  task automatic go_phase(input int ph, input logic mode);
    hold(mode);
    rst_n = 1'b0; tick; tick;
    rst_n = 1'b1;
    if (ph >= 1) begin bv = 1'b1; tick; bv = 1'b0; end
    if (ph >= 2) begin dt = 1'b1; tick; dt = 1'b0; end
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) tick;
    chk("R1 reset state", 5'b01000);
    bv = 1'b1; #0.5;
    chk("R1 reset with valley", 5'b00000);
    bv = 1'b0;
    rst_n = 1'b1; tick;
    chk("R2 discharge above valley", 5'b01000);
    bv = 1'b1; #0.5;
    chk("R2 discharge drops without clock", 5'b00000);
    tick; bv = 1'b0;
    chk("R3 regulation after valley", 5'b00100);
    si = 1'b1;
    repeat (3) tick;
    chk("R10 dead time low holds regulation", 5'b00100);
    dt = 1'b1; tick; dt = 1'b0;
    chk("R4 charge start, R7 sf high", 5'b10011);
    bm = 1'b0; #0.5;
    chk("R7 sf low above mid", 5'b10000);
    bm = 1'b1; #0.5;
    chk("R7 sf high again", 5'b10011);
    pwm = 1'b1; #0.5;
    chk("R8 vs drops on pwm", 5'b10010);
    tick; pwm = 1'b0; #0.5;
    chk("R8 vs stays low after pwm clears", 5'b10010);
    si = 1'b0; bm = 1'b0; tick;
    chk("R9 free mode ignores sync and mid", 5'b10000);
    bm = 1'b1; pk = 1'b1; tick; pk = 1'b0;
    chk("R5 peak ends charge", 5'b01000);
    bv = 1'b1; tick; bv = 1'b0;
    chk("R3 second cycle regulation", 5'b00100);
    dt = 1'b1; tick; dt = 1'b0;
    chk("R8 vs released in new cycle", 5'b10011);
    pk = 1'b1; tick; pk = 1'b0;
    chk("R5 second peak end", 5'b01000);

    sm = 1'b1; si = 1'b0; bv = 1'b1; tick; bv = 1'b0;
    chk("R6 sync mode regulation", 5'b00100);
    dt = 1'b1; tick;
    chk("R6 sync low blocks charge", 5'b00100);
    si = 1'b1; tick; dt = 1'b0;
    chk("R6 sync high starts charge", 5'b10011);
    bm = 1'b0; tick; tick;
    chk("R6 wide sync keeps charging past mid", 5'b10000);
    pk = 1'b1; tick; pk = 1'b0;
    chk("R6 peak ignored in sync mode", 5'b10000);
    si = 1'b0; tick;
    chk("R6 sync low above mid ends charge", 5'b01000);
    bm = 1'b1; bv = 1'b1; tick; bv = 1'b0;
    dt = 1'b1; si = 1'b1; tick; si = 1'b0; dt = 1'b0;
    chk("R6 narrow sync starts charge", 5'b10011);
    tick;
    chk("R6 narrow sync below mid keeps charging", 5'b10011);
    bm = 1'b0; tick;
    chk("R6 narrow sync ends at mid", 5'b01000);

    for (int mode = 0; mode < 2; mode++) begin
      for (int ph = 0; ph < 3; ph++) begin
        go_phase(ph, mode[0]);
        for (int v = 0; v < 64; v++) begin
          logic [4:0] exp;
          @(negedge clk);
          {bv, bm, pk, si, dt, pwm} = v[5:0];
          exp[4] = (ph == 2);
          exp[3] = (ph == 0) && !v[5];
          exp[2] = (ph == 1);
          exp[1] = (ph == 2) && v[4];
          exp[0] = (ph == 2) && v[4] && !v[0];
          #0.5;
          chk($sformatf("R2 R3 R4 R7 R8 sweep mode=%0d phase=%0d v=%0d", mode, ph, v), exp);
          hold(mode[0]);
        end
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule